// File: doc/BRIEF.md
# Parallel BCH(15,7) Frame Codec

This block adds forward error correction to a 56-bit frame payload. The payload is a 4-bit header (nominally `1010`) and 52 data bits that have already been scrambled. The payload is cut into eight 7-bit messages. Each message is protected by its own binary BCH code of length 15 that corrects two errors. The eight 15-bit codewords are packed into one 120-bit line word, so 64 bits of every frame are parity.

The codec has two independent paths on one clock. The encode path takes a valid-qualified payload and returns the 120-bit frame one cycle later. The decode path takes a valid-qualified 120-bit frame and returns the 56-bit payload two cycles later. Along with the payload it gives two per-lane flags: one marks a lane that was repaired, the other marks a lane that could not be decoded. Each lane decodes without reference to the others, so a frame can recover from as many as sixteen scattered bit errors, at most two in each lane.

Top module: `bch_frame_codec`

## Requirements
- R1: Each lane codeword is systematic. Bits [14:8] hold the 7-bit message. Bits [7:0] hold the remainder of message·x^8 divided by g(x) = x^8+x^7+x^6+x^4+1, where codeword bit i is the coefficient of x^i.
- R2: Lane k (k = 0..7) takes payload bits [55-7k -: 7] and puts its codeword in frame bits [119-15k -: 15]. The header in payload[55:52] therefore appears unchanged in frame[119:116].
- R3: `enc_valid_o` and `enc_frame_o` reflect the encode inputs sampled on the previous rising edge, which is one cycle of latency.
- R4: `dec_valid_o`, `dec_payload_o` and both flag vectors reflect the decode inputs sampled two rising edges earlier.
- R5: A lane holding an error-free codeword returns its message, with both flags for that lane clear.
- R6: A single flipped bit at any of the 15 positions of a lane is repaired, and the repaired flag of that lane (bit k of `dec_fixed_o`) is set.
- R7: Any two flipped bits within one lane are repaired, and the repaired flag of that lane is set.
- R8: If a lane's received word is more than two bits away from every codeword, the failure flag of that lane (bit k of `dec_fail_o`) is set. The repaired flag stays clear, and the received bits [14:8] are returned unchanged.
- R9: Lanes decode independently. Two errors in each of the eight lanes (sixteen in total) are all repaired in the same frame.
- R10: While `rst` is high, and on the cycle after it falls, both output valids are low.
- R11: No lane ever has its repaired flag and its failure flag set together, and both flag vectors read zero while `dec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encode payload is valid |
| enc_payload_i | input | 56 | Header and scrambled data to protect |
| enc_valid_o | output | 1 | Encoded frame is valid |
| enc_frame_o | output | 120 | Eight packed 15-bit codewords |
| dec_valid_i | input | 1 | Received frame is valid |
| dec_frame_i | input | 120 | Received 120-bit frame |
| dec_valid_o | output | 1 | Decoded payload is valid |
| dec_payload_o | output | 56 | Corrected payload |
| dec_fixed_o | output | 8 | Per-lane flag: errors were repaired |
| dec_fail_o | output | 8 | Per-lane flag: the lane could not be decoded |

## Verification
The bench flips a single bit at every one of the 120 frame positions, one at a time. A syndrome or root search with a wrong power-of-alpha table would repair the wrong bit, or would report a failure on a lane that can be repaired. Random double errors in each lane, and a frame with two errors in every lane, check the quadratic root test and the independence of the lanes. A design that mixed lane slices, or that accepted one root as enough, would return a corrupted payload. Lanes with three to five errors check the root-count test: a design that trusted the locator would raise the repaired flag on garbage and alter the message bits. A one-hot payload sweep catches lanes that are swapped or bit-reversed in the packing.

// File: rtl/bch_codec_pkg.sv
package bch_codec_pkg;

    localparam int MSG_W = 7;
    localparam int PAR_W = 8;
    localparam int CW_W  = MSG_W + PAR_W;
    localparam int GF_W  = 4;
    localparam int GF_N  = 15;

    // g(x) without its x^8 term: x^7 + x^6 + x^4 + 1
    localparam logic [PAR_W-1:0] GEN_LOW = 8'hD1;
    // reduction of x^4 in GF(16) built on x^4 + x + 1
    localparam logic [GF_W-1:0]  FIELD_LOW = 4'b0011;

    typedef enum logic [1:0] {
        ERR_NONE,
        ERR_ONE,
        ERR_TWO
    } err_kind_e;

    typedef struct packed {
        logic [GF_W-1:0]  s1;
        logic [GF_W-1:0]  s3;
        logic [MSG_W-1:0] msg;
    } syn_t;

    typedef struct packed {
        logic [MSG_W-1:0] msg;
        logic             fixed;
        logic             fail;
    } lane_res_t;

    function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                               input logic [GF_W-1:0] b);
        logic [GF_W-1:0] acc;
        logic [GF_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[GF_W-1] ? ({sh[GF_W-2:0], 1'b0} ^ FIELD_LOW)
                            : {sh[GF_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [GF_W-1:0] gf_alpha(input int e);
        logic [GF_W-1:0] r;
        int em;
        em = e % GF_N;
        r  = 4'b0001;
        for (int i = 0; i < GF_N; i++) begin
            if (i < em) r = gf_mul(r, 4'b0010);
        end
        return r;
    endfunction

    function automatic logic [CW_W-1:0] bch_encode(input logic [MSG_W-1:0] m);
        logic [PAR_W-1:0] rem;
        logic fb;
        rem = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb  = m[i] ^ rem[PAR_W-1];
            rem = {rem[PAR_W-2:0], 1'b0};
            if (fb) rem = rem ^ GEN_LOW;
        end
        return {m, rem};
    endfunction

    function automatic syn_t bch_syndromes(input logic [CW_W-1:0] r);
        syn_t s;
        s.s1  = '0;
        s.s3  = '0;
        s.msg = r[CW_W-1:PAR_W];
        for (int i = 0; i < CW_W; i++) begin
            if (r[i]) begin
                s.s1 = s.s1 ^ gf_alpha(i);
                s.s3 = s.s3 ^ gf_alpha(3 * i);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/bch_lane_encoder.sv
module bch_lane_encoder
    import bch_codec_pkg::*;
(
    input  logic             clk,
    input  logic [MSG_W-1:0] msg_i,
    output logic [CW_W-1:0]  cw_o
);

    logic [CW_W-1:0] cw_q;

    always_ff @(posedge clk) begin
        cw_q <= bch_encode(msg_i);
    end

    assign cw_o = cw_q;

endmodule

// File: rtl/bch_lane_decoder.sv
module bch_lane_decoder
    import bch_codec_pkg::*;
(
    input  logic            clk,
    input  logic [CW_W-1:0] cw_i,
    output lane_res_t       res_o
);

    // stage 1: syndromes plus received message bits
    syn_t syn_q;

    always_ff @(posedge clk) begin
        syn_q <= bch_syndromes(cw_i);
    end

    // stage 2: classify, locate, correct
    err_kind_e       kind;
    logic [GF_W-1:0] s1_sq;
    logic [GF_W-1:0] s1_cu;
    logic [CW_W-1:0] loc;
    logic [3:0]      roots;
    lane_res_t       res_d;
    lane_res_t       res_q;

    always_comb begin
        s1_sq = gf_mul(syn_q.s1, syn_q.s1);
        s1_cu = gf_mul(s1_sq, syn_q.s1);

        if (syn_q.s1 == '0 && syn_q.s3 == '0)
            kind = ERR_NONE;
        else if (syn_q.s3 == s1_cu)
            kind = ERR_ONE;
        else
            kind = ERR_TWO;

        // position j is a root when z = alpha^j satisfies the scaled locator
        loc   = '0;
        roots = '0;
        for (int j = 0; j < CW_W; j++) begin
            logic [GF_W-1:0] z;
            logic [GF_W-1:0] q;
            z = gf_alpha(j);
            q = gf_mul(syn_q.s1, gf_mul(z, z)) ^ gf_mul(s1_sq, z)
                ^ syn_q.s3 ^ s1_cu;
            unique case (kind)
                ERR_ONE:  loc[j] = (z == syn_q.s1);
                ERR_TWO:  loc[j] = (q == '0);
                default:  loc[j] = 1'b0;
            endcase
            roots = roots + {3'b000, loc[j]};
        end

        res_d.fail  = (kind == ERR_ONE && roots != 4'd1) ||
                      (kind == ERR_TWO && roots != 4'd2);
        res_d.fixed = (kind != ERR_NONE) && !res_d.fail;
        res_d.msg   = res_d.fail ? syn_q.msg
                                 : (syn_q.msg ^ loc[CW_W-1:PAR_W]);
    end

    always_ff @(posedge clk) begin
        res_q <= res_d;
    end

    assign res_o = res_q;

endmodule

// File: rtl/bch_frame_codec.sv
module bch_frame_codec
    import bch_codec_pkg::*;
#(
    parameter int LANES = 8,
    localparam int PAYLOAD_W = LANES * MSG_W,
    localparam int FRAME_W   = LANES * CW_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enc_valid_i,
    input  logic [PAYLOAD_W-1:0] enc_payload_i,
    output logic                 enc_valid_o,
    output logic [FRAME_W-1:0]   enc_frame_o,
    input  logic                 dec_valid_i,
    input  logic [FRAME_W-1:0]   dec_frame_i,
    output logic                 dec_valid_o,
    output logic [PAYLOAD_W-1:0] dec_payload_o,
    output logic [LANES-1:0]     dec_fixed_o,
    output logic [LANES-1:0]     dec_fail_o
);

    logic enc_v_q;
    logic dec_v1_q;
    logic dec_v2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_v_q  <= 1'b0;
            dec_v1_q <= 1'b0;
            dec_v2_q <= 1'b0;
        end else begin
            enc_v_q  <= enc_valid_i;
            dec_v1_q <= dec_valid_i;
            dec_v2_q <= dec_v1_q;
        end
    end

    logic [LANES-1:0] fixed_raw;
    logic [LANES-1:0] fail_raw;

    // lane 0 sits at the top of both the payload and the frame
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_res_t res;

        bch_lane_encoder u_enc (
            .clk   (clk),
            .msg_i (enc_payload_i[PAYLOAD_W-1-MSG_W*k -: MSG_W]),
            .cw_o  (enc_frame_o[FRAME_W-1-CW_W*k -: CW_W])
        );

        bch_lane_decoder u_dec (
            .clk   (clk),
            .cw_i  (dec_frame_i[FRAME_W-1-CW_W*k -: CW_W]),
            .res_o (res)
        );

        assign dec_payload_o[PAYLOAD_W-1-MSG_W*k -: MSG_W] = res.msg;
        assign fixed_raw[k] = res.fixed;
        assign fail_raw[k]  = res.fail;
    end

    assign enc_valid_o = enc_v_q;
    assign dec_valid_o = dec_v2_q;
    assign dec_fixed_o = fixed_raw & {LANES{dec_v2_q}};
    assign dec_fail_o  = fail_raw  & {LANES{dec_v2_q}};

endmodule

// File: rtl/bch_frame_codec_chk.sv
module bch_frame_codec_chk
    import bch_codec_pkg::*;
#(
    parameter int LANES = 8,
    localparam int PAYLOAD_W = LANES * MSG_W,
    localparam int FRAME_W   = LANES * CW_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enc_valid_i,
    input logic [PAYLOAD_W-1:0] enc_payload_i,
    input logic                 enc_valid_o,
    input logic [FRAME_W-1:0]   enc_frame_o,
    input logic                 dec_valid_i,
    input logic [FRAME_W-1:0]   dec_frame_i,
    input logic                 dec_valid_o,
    input logic [PAYLOAD_W-1:0] dec_payload_o,
    input logic [LANES-1:0]     dec_fixed_o,
    input logic [LANES-1:0]     dec_fail_o
);

    assert_enc_latency_R3: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o);

    assert_enc_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> !enc_valid_o);

    assert_dec_latency_R4: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> ##1 dec_valid_o);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!enc_valid_o && !dec_valid_o));

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        (dec_fixed_o & dec_fail_o) == '0);

    assert_flags_gated_R11: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_o |-> (dec_fixed_o == '0 && dec_fail_o == '0));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        assert_systematic_R1: assert property (@(posedge clk) disable iff (rst)
            enc_valid_i |=> enc_frame_o[FRAME_W-1-CW_W*k -: MSG_W]
                            == $past(enc_payload_i[PAYLOAD_W-1-MSG_W*k -: MSG_W]));

        assert_fail_passthru_R8: assert property (@(posedge clk) disable iff (rst)
            (dec_valid_o && dec_fail_o[k]) |->
                dec_payload_o[PAYLOAD_W-1-MSG_W*k -: MSG_W]
                == $past(dec_frame_i[FRAME_W-1-CW_W*k -: MSG_W], 2));
    end

endmodule

bind bch_frame_codec bch_frame_codec_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enc_valid_i   (enc_valid_i),
    .enc_payload_i (enc_payload_i),
    .enc_valid_o   (enc_valid_o),
    .enc_frame_o   (enc_frame_o),
    .dec_valid_i   (dec_valid_i),
    .dec_frame_i   (dec_frame_i),
    .dec_valid_o   (dec_valid_o),
    .dec_payload_o (dec_payload_o),
    .dec_fixed_o   (dec_fixed_o),
    .dec_fail_o    (dec_fail_o)
);

// File: tb/bch_frame_codec_bench.sv
`timescale 1ns/100ps
module bch_frame_codec_bench;

    localparam int NL = 8;
    localparam int PW = 56;
    localparam int FW = 120;
    localparam int WATCHDOG_CYCLES = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enc_valid_i = 1'b0;
    logic [PW-1:0] enc_payload_i = '0;
    logic          enc_valid_o;
    logic [FW-1:0] enc_frame_o;
    logic          dec_valid_i = 1'b0;
    logic [FW-1:0] dec_frame_i = '0;
    logic          dec_valid_o;
    logic [PW-1:0] dec_payload_o;
    logic [NL-1:0] dec_fixed_o;
    logic [NL-1:0] dec_fail_o;

    always #2.5 clk = ~clk;

    bch_frame_codec u_bch_frame_codec (
        .clk           (clk),
        .rst           (rst),
        .enc_valid_i   (enc_valid_i),
        .enc_payload_i (enc_payload_i),
        .enc_valid_o   (enc_valid_o),
        .enc_frame_o   (enc_frame_o),
        .dec_valid_i   (dec_valid_i),
        .dec_frame_i   (dec_frame_i),
        .dec_valid_o   (dec_valid_o),
        .dec_payload_o (dec_payload_o),
        .dec_fixed_o   (dec_fixed_o),
        .dec_fail_o    (dec_fail_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [14:0] codebook [128];

    // expected pipeline state
    logic          x_enc_v;
    logic [FW-1:0] x_enc_f;
    string         x_enc_tag;
    logic          x_dec_v   [2];
    logic [PW-1:0] x_dec_p   [2];
    logic [NL-1:0] x_dec_fix [2];
    logic [NL-1:0] x_dec_bad [2];
    string         x_dec_tag [2];

    // remainder of a 15-bit polynomial modulo g(x) = 0x1D1
    function automatic logic [7:0] poly_rem(input logic [14:0] w);
        logic [14:0] t;
        t = w;
        for (int i = 14; i >= 8; i--)
            if (t[i]) t = t ^ (15'h1D1 << (i - 8));
        return t[7:0];
    endfunction

    function automatic logic [FW-1:0] build_frame(input logic [PW-1:0] p);
        logic [FW-1:0] f;
        f = '0;
        for (int k = 0; k < NL; k++)
            f[FW-1-15*k -: 15] = codebook[p[PW-1-7*k -: 7]];
        return f;
    endfunction

    task automatic ref_decode(input logic [FW-1:0] f, output logic [PW-1:0] p,
                              output logic [NL-1:0] fix, output logic [NL-1:0] bad);
        for (int k = 0; k < NL; k++) begin
            logic [14:0] rx;
            int best, best_m;
            rx = f[FW-1-15*k -: 15];
            best = 99;
            best_m = 0;
            for (int m = 0; m < 128; m++) begin
                int d;
                d = $countones(codebook[m] ^ rx);
                if (d < best) begin best = d; best_m = m; end
            end
            if (best <= 2) begin
                p[PW-1-7*k -: 7] = 7'(best_m);
                fix[k] = (best != 0);
                bad[k] = 1'b0;
            end else begin
                p[PW-1-7*k -: 7] = rx[14:8];
                fix[k] = 1'b0;
                bad[k] = 1'b1;
            end
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check("R3", "enc_valid", FW'(enc_valid_o), FW'(x_enc_v));
        if (x_enc_v) check(x_enc_tag, "enc_frame", enc_frame_o, x_enc_f);
        check("R4", "dec_valid", FW'(dec_valid_o), FW'(x_dec_v[1]));
        if (x_dec_v[1]) begin
            check(x_dec_tag[1], "dec_payload", FW'(dec_payload_o), FW'(x_dec_p[1]));
            check(x_dec_tag[1], "dec_fixed",   FW'(dec_fixed_o),   FW'(x_dec_fix[1]));
            check(x_dec_tag[1], "dec_fail",    FW'(dec_fail_o),    FW'(x_dec_bad[1]));
        end else begin
            check("R11", "idle flags", FW'({dec_fixed_o, dec_fail_o}), '0);
        end
    endtask

    task automatic cycle(input logic ev, input logic [PW-1:0] ep, input string etag,
                         input logic dv, input logic [FW-1:0] df, input string dtag);
        logic [PW-1:0] p;
        logic [NL-1:0] fx, bd;
        @(negedge clk);
        compare_outputs();
        enc_valid_i   = ev;
        enc_payload_i = ep;
        dec_valid_i   = dv;
        dec_frame_i   = df;
        x_enc_v   = ev;
        x_enc_f   = build_frame(ep);
        x_enc_tag = etag;
        x_dec_v[1]   = x_dec_v[0];
        x_dec_p[1]   = x_dec_p[0];
        x_dec_fix[1] = x_dec_fix[0];
        x_dec_bad[1] = x_dec_bad[0];
        x_dec_tag[1] = x_dec_tag[0];
        ref_decode(df, p, fx, bd);
        x_dec_v[0]   = dv;
        x_dec_p[0]   = p;
        x_dec_fix[0] = fx;
        x_dec_bad[0] = bd;
        x_dec_tag[0] = dtag;
    endtask

    task automatic enc(input logic [PW-1:0] p, input string tag);
        cycle(1'b1, p, tag, 1'b0, '0, "R4");
    endtask

    task automatic dec(input logic [FW-1:0] f, input string tag);
        cycle(1'b0, '0, "R3", 1'b1, f, tag);
    endtask

    task automatic idle();
        cycle(1'b0, '0, "R3", 1'b0, '0, "R4");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        check("R10", "valids in reset", FW'({enc_valid_o, dec_valid_o}), '0);
        rst = 1'b0;
        x_enc_v = 1'b0;
        x_dec_v[0] = 1'b0;
        x_dec_v[1] = 1'b0;
    endtask

    function automatic logic [PW-1:0] rnd_payload(input logic hdr);
        logic [PW-1:0] p;
        p = {$urandom, $urandom};
        if (hdr) p[55:52] = 4'b1010;
        return p;
    endfunction

    function automatic logic [FW-1:0] lane_errs(input int k, input int n);
        logic [14:0] e;
        logic [FW-1:0] f;
        e = '0;
        while ($countones(e) < n) e[$urandom % 15] = 1'b1;
        f = '0;
        f[FW-1-15*k -: 15] = e;
        return f;
    endfunction

    initial begin
        #(WATCHDOG_CYCLES * 5.0);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m < 128; m++)
            for (int par = 0; par < 256; par++)
                if (poly_rem({7'(m), 8'(par)}) == 8'h00)
                    codebook[m] = {7'(m), 8'(par)};
        x_enc_v = 1'b0;
        x_enc_f = '0;
        x_enc_tag = "R3";
        for (int i = 0; i < 2; i++) begin
            x_dec_v[i] = 1'b0; x_dec_p[i] = '0;
            x_dec_fix[i] = '0; x_dec_bad[i] = '0; x_dec_tag[i] = "R4";
        end

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", "valids in reset", FW'({enc_valid_o, dec_valid_o}), '0);
        rst = 1'b0;
        idle();

        // R1: encoder with header and random data
        enc('0, "R1");
        enc({4'b1010, 52'hF_FFFF_FFFF_FFFF}, "R1");
        for (int i = 0; i < 40; i++) enc(rnd_payload(1'b1), "R1");
        // R2: one-hot sweep exposes lane placement and bit order
        for (int b = 0; b < PW; b++) enc(PW'(1) << b, "R2");
        idle();

        // R5: clean frames
        for (int i = 0; i < 20; i++) dec(build_frame(rnd_payload(1'b1)), "R5");
        // R6: every single-bit position in the frame
        for (int pos = 0; pos < FW; pos++)
            dec(build_frame(rnd_payload(1'b1)) ^ (FW'(1) << pos), "R6");
        // R7: two errors in one lane
        for (int i = 0; i < 64; i++)
            dec(build_frame(rnd_payload(1'b1)) ^ lane_errs(i % NL, 2), "R7");
        // R9: two errors in every lane at once
        for (int i = 0; i < 20; i++) begin
            logic [FW-1:0] e;
            e = '0;
            for (int k = 0; k < NL; k++) e = e | lane_errs(k, 2);
            dec(build_frame(rnd_payload(1'b1)) ^ e, "R9");
        end
        // R8: beyond capability
        for (int i = 0; i < 60; i++)
            dec(build_frame(rnd_payload(1'b1)) ^ lane_errs(i % NL, 3 + (i % 3)), "R8");
        // R3/R4: encode and decode simultaneously, with gaps
        for (int i = 0; i < 30; i++) begin
            logic [PW-1:0] p;
            p = rnd_payload(1'b1);
            cycle(i[0], p, "R3", i[1] | i[0], build_frame(p) ^ lane_errs(i % NL, 1), "R4");
        end
        idle();
        idle();

        // R10: reset while data in flight
        enc(rnd_payload(1'b1), "R1");
        dec(build_frame(rnd_payload(1'b1)), "R5");
        do_reset();
        idle();
        idle();
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule